// File: doc/BRIEF.md
# Watermark FIFO with Sticky Error Flags

A single-clock, 32-bit-wide first-in first-out buffer that sits in front of a DMA-style requester. Data goes in through a push strobe and comes out through a pop strobe. The popped word appears on a registered output one cycle after the pop. A small register port carries the configuration and a status word. The port is a strobe-based read and write interface with a two-bit address.

The block raises a data-request alarm from its fill level. The low condition sets once the level has drained to a programmable low mark. It then holds, so the request stays up while the buffer refills. It drops only when the free space shrinks to the granularity setting, which is counted in longwords. The high condition reports that free space is at or below the same granularity. Enable bits select which condition reaches the alarm pin.

A push to a full buffer is discarded. A pop from an empty buffer returns zero. In both cases the pointers stay where they are, and the event is recorded in a sticky flag that software clears by writing one. A software reset bit empties the buffer and clears both flags in a single cycle.

Top module: `wm_fifo`

## Requirements
- R1: After the synchronous reset, empty is 1 and full, alarm and pop_data are 0. The control register and the low-mark register read back as 0.
- R2: Accepted words leave in the order they were pushed. The word appears on pop_data in the cycle after the pop strobe.
- R3: A push while full is dropped and the level stays at full. The overflow flag (status bit 4) sets and stays set until a write of 1 to status bit 4 or a software reset. If a set and a clear fall in the same cycle, the set wins.
- R4: A pop while empty moves no pointer and puts zero on pop_data in the next cycle. It sets the sticky underflow flag (status bit 5), which is cleared the same way as overflow.
- R5: full and empty follow the current level with no memory. The status register shows empty at bit 0, full at bit 3 and the level starting at bit 8.
- R6: The high flag (status bit 2) is registered. One cycle after the level leaves free space less than or equal to the granularity value, the flag reads 1. Otherwise it reads 0.
- R7: The low flag (status bit 1) is registered and has hysteresis. It clears when free space is at or below the granularity. Otherwise it sets when the level is at or below the low mark (register address 1). In all other cases it holds its value.
- R8: A granularity of 0 keeps the low flag up until the buffer is completely full. A granularity of 1 drops it when exactly one free word remains.
- R9: alarm equals (high flag AND control bit 2) OR (low flag AND control bit 1).
- R10: Writing 1 to control bit 8 empties the buffer and clears both sticky flags at that clock edge. A push in the same cycle is discarded. Bit 8 reads back as 0.
- R11: The frame-end bit (control bit 0) is stored and reads back. It has no effect on the data path.
- R12: reg_rdata is registered. One cycle after reg_rd, it holds the value the register had before that edge. Address 0 is control, with the granularity at bits 6:4. Address 1 is the low mark, address 2 is status, and address 3 reads zero.
- R13: A simultaneous push and pop on a buffer that is neither empty nor full leaves the level unchanged. On an empty buffer the push is accepted and the pop underflows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push | input | 1 | Write strobe |
| push_data | input | DATA_W | Word to store |
| pop | input | 1 | Read strobe |
| pop_data | output | DATA_W | Popped word, valid the cycle after pop |
| full | output | 1 | Level equals depth |
| empty | output | 1 | Level is zero |
| alarm | output | 1 | Data-request alarm |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |

## Verification
The bench builds the block with a depth of 8 and a data width of 32. At that depth a few pushes reach the full boundary, overflow and pointer wraparound. The largest granularity of 7 then covers almost the whole range of levels, so the hysteresis and the high flag are exercised at both extremes of the granularity field. A behavioural queue model predicts full, empty, alarm, popped words and register reads on every cycle.

// File: rtl/wm_fifo_pkg.sv
package wm_fifo_pkg;

  localparam int GRAN_W = 3;

  typedef enum logic [1:0] {
    ADDR_CTRL    = 2'd0,
    ADDR_LOWMARK = 2'd1,
    ADDR_STATUS  = 2'd2,
    ADDR_SPARE   = 2'd3
  } reg_addr_e;

  // control register bit positions
  localparam int CTRL_FRAME_END = 0;
  localparam int CTRL_LO_EN     = 1;
  localparam int CTRL_HI_EN     = 2;
  localparam int CTRL_GRAN_LSB  = 4;
  localparam int CTRL_SRST      = 8;

  // status register bit positions
  localparam int ST_EMPTY   = 0;
  localparam int ST_LO      = 1;
  localparam int ST_HI      = 2;
  localparam int ST_FULL    = 3;
  localparam int ST_OVF     = 4;
  localparam int ST_UNF     = 5;
  localparam int ST_LVL_LSB = 8;

  typedef struct packed {
    logic              frame_end;
    logic              lo_en;
    logic              hi_en;
    logic [GRAN_W-1:0] gran;
  } ctrl_t;

endpackage

// File: rtl/wm_fifo_mem.sv
module wm_fifo_mem #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] store [DEPTH];

  // simple dual-port RAM with registered read, block RAM friendly
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end

endmodule

// File: rtl/wm_fifo_ctl.sv
module wm_fifo_ctl #(
  parameter int DEPTH = 64,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LVL_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              srst,
  input  logic              push,
  input  logic              pop,
  input  logic              clr_ovf,
  input  logic              clr_unf,
  output logic              we,
  output logic              re,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic [LVL_W-1:0]  level,
  output logic              full,
  output logic              empty,
  output logic              ovf,
  output logic              unf
);

  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  assign full  = (level == FULL_LVL);
  assign empty = (level == '0);

  // accepted accesses only; rejected ones only touch the error flags
  assign we = push && !full && !srst;
  assign re = pop && !empty;

  always_ff @(posedge clk) begin
    if (rst || srst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (we) wr_ptr <= wr_ptr + ADDR_W'(1);
      if (re) rd_ptr <= rd_ptr + ADDR_W'(1);
      level <= level + LVL_W'(we) - LVL_W'(re);
    end
  end

  // sticky flags: setting event beats a software clear
  always_ff @(posedge clk) begin
    if (rst || srst) begin
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      if (push && full)  ovf <= 1'b1;
      else if (clr_ovf)  ovf <= 1'b0;
      if (pop && empty)  unf <= 1'b1;
      else if (clr_unf)  unf <= 1'b0;
    end
  end

endmodule

// File: rtl/wm_fifo_alarm.sv
module wm_fifo_alarm
  import wm_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int LVL_W = $clog2(DEPTH) + 1,
  localparam int CMP_W = (LVL_W > GRAN_W) ? LVL_W : GRAN_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LVL_W-1:0]  level,
  input  logic [GRAN_W-1:0] gran,
  input  logic [LVL_W-1:0]  low_mark,
  output logic              hi,
  output logic              lo
);

  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [LVL_W-1:0] free_cnt;
  logic             room_short;

  assign free_cnt   = FULL_LVL - level;
  assign room_short = (CMP_W'(free_cnt) <= CMP_W'(gran));

  always_ff @(posedge clk) begin
    if (rst) begin
      hi <= 1'b0;
      lo <= 1'b0;
    end else begin
      hi <= room_short;
      if (room_short)            lo <= 1'b0;
      else if (level <= low_mark) lo <= 1'b1;
    end
  end

endmodule

// File: rtl/wm_fifo_regs.sv
module wm_fifo_regs
  import wm_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LVL_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output ctrl_t             cfg,
  output logic [LVL_W-1:0]  low_mark,
  output logic              srst,
  output logic              clr_ovf,
  output logic              clr_unf,
  input  logic              st_empty,
  input  logic              st_lo,
  input  logic              st_hi,
  input  logic              st_full,
  input  logic              st_ovf,
  input  logic              st_unf,
  input  logic [LVL_W-1:0]  st_level
);

  reg_addr_e         addr;
  logic              wr_ctrl;
  logic              wr_stat;
  logic [DATA_W-1:0] rd_val;

  assign addr    = reg_addr_e'(reg_addr);
  assign wr_ctrl = reg_wr && (addr == ADDR_CTRL);
  assign wr_stat = reg_wr && (addr == ADDR_STATUS);
  assign srst    = wr_ctrl && reg_wdata[CTRL_SRST];
  assign clr_ovf = wr_stat && reg_wdata[ST_OVF];
  assign clr_unf = wr_stat && reg_wdata[ST_UNF];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg      <= '0;
      low_mark <= '0;
    end else begin
      if (wr_ctrl) begin
        cfg.frame_end <= reg_wdata[CTRL_FRAME_END];
        cfg.lo_en     <= reg_wdata[CTRL_LO_EN];
        cfg.hi_en     <= reg_wdata[CTRL_HI_EN];
        cfg.gran      <= reg_wdata[CTRL_GRAN_LSB +: GRAN_W];
      end
      if (reg_wr && (addr == ADDR_LOWMARK)) low_mark <= reg_wdata[LVL_W-1:0];
    end
  end

  always_comb begin
    rd_val = '0;
    case (addr)
      ADDR_CTRL: begin
        rd_val[CTRL_FRAME_END]             = cfg.frame_end;
        rd_val[CTRL_LO_EN]                 = cfg.lo_en;
        rd_val[CTRL_HI_EN]                 = cfg.hi_en;
        rd_val[CTRL_GRAN_LSB +: GRAN_W]    = cfg.gran;
      end
      ADDR_LOWMARK: rd_val[LVL_W-1:0] = low_mark;
      ADDR_STATUS: begin
        rd_val[ST_EMPTY]               = st_empty;
        rd_val[ST_LO]                  = st_lo;
        rd_val[ST_HI]                  = st_hi;
        rd_val[ST_FULL]                = st_full;
        rd_val[ST_OVF]                 = st_ovf;
        rd_val[ST_UNF]                 = st_unf;
        rd_val[ST_LVL_LSB +: LVL_W]    = st_level;
      end
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
  end

endmodule

// File: rtl/wm_fifo.sv
module wm_fifo
  import wm_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic              full,
  output logic              empty,
  output logic              alarm,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);

  localparam int ADDR_W = $clog2(DEPTH);
  localparam int LVL_W  = ADDR_W + 1;

  ctrl_t             cfg;
  logic [LVL_W-1:0]  low_mark;
  logic              srst;
  logic              clr_ovf;
  logic              clr_unf;
  logic              we;
  logic              re;
  logic [ADDR_W-1:0] wr_ptr;
  logic [ADDR_W-1:0] rd_ptr;
  logic [LVL_W-1:0]  level;
  logic              ovf_flag;
  logic              unf_flag;
  logic              hi_flag;
  logic              lo_flag;
  logic [DATA_W-1:0] ram_q;
  logic              zero_q;

  wm_fifo_regs #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .cfg      (cfg),
    .low_mark (low_mark),
    .srst     (srst),
    .clr_ovf  (clr_ovf),
    .clr_unf  (clr_unf),
    .st_empty (empty),
    .st_lo    (lo_flag),
    .st_hi    (hi_flag),
    .st_full  (full),
    .st_ovf   (ovf_flag),
    .st_unf   (unf_flag),
    .st_level (level)
  );

  wm_fifo_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk    (clk),
    .rst    (rst),
    .srst   (srst),
    .push   (push),
    .pop    (pop),
    .clr_ovf(clr_ovf),
    .clr_unf(clr_unf),
    .we     (we),
    .re     (re),
    .wr_ptr (wr_ptr),
    .rd_ptr (rd_ptr),
    .level  (level),
    .full   (full),
    .empty  (empty),
    .ovf    (ovf_flag),
    .unf    (unf_flag)
  );

  wm_fifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk  (clk),
    .we   (we),
    .waddr(wr_ptr),
    .wdata(push_data),
    .re   (re),
    .raddr(rd_ptr),
    .rdata(ram_q)
  );

  wm_fifo_alarm #(.DEPTH(DEPTH)) u_alarm (
    .clk     (clk),
    .rst     (rst),
    .level   (level),
    .gran    (cfg.gran),
    .low_mark(low_mark),
    .hi      (hi_flag),
    .lo      (lo_flag)
  );

  // an underflowing pop masks the RAM output to zero
  always_ff @(posedge clk) begin
    if (rst)      zero_q <= 1'b1;
    else if (pop) zero_q <= empty;
  end

  assign pop_data = zero_q ? '0 : ram_q;
  assign alarm    = (hi_flag & cfg.hi_en) | (lo_flag & cfg.lo_en);

endmodule

// File: rtl/wm_fifo_chk.sv
module wm_fifo_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              push,
  input logic              pop,
  input logic              full,
  input logic              empty,
  input logic [DATA_W-1:0] pop_data,
  input logic              srst,
  input logic              clr_ovf,
  input logic              clr_unf,
  input logic              ovf,
  input logic              unf,
  input logic              hi,
  input logic              lo
);

  assert_full_empty_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

  assert_drop_keeps_full_R3: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !srst) |=> full);

  assert_ovf_set_R3: assert property (@(posedge clk) disable iff (rst)
    (push && full && !srst) |=> ovf);

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (ovf && !clr_ovf && !srst) |=> ovf);

  assert_unf_set_R4: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !srst) |=> unf);

  assert_unf_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    (unf && !clr_unf && !srst) |=> unf);

  assert_unf_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (pop && empty) |=> (pop_data == '0));

  assert_srst_clears_R10: assert property (@(posedge clk) disable iff (rst)
    srst |=> (empty && !ovf && !unf));

  assert_hi_lo_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(hi && lo));

endmodule

bind wm_fifo wm_fifo_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .push    (push),
  .pop     (pop),
  .full    (full),
  .empty   (empty),
  .pop_data(pop_data),
  .srst    (srst),
  .clr_ovf (clr_ovf),
  .clr_unf (clr_unf),
  .ovf     (ovf_flag),
  .unf     (unf_flag),
  .hi      (hi_flag),
  .lo      (lo_flag)
);

// File: tb/sim_wm_fifo.sv
module sim_wm_fifo;

  localparam int DATA_W = 32;
  localparam int DEPTH  = 8;
  localparam int LVL_W  = $clog2(DEPTH) + 1;

  logic              clk = 1'b0;
  logic              rst;
  logic              push, pop, reg_wr, reg_rd;
  logic [DATA_W-1:0] push_data, reg_wdata;
  logic [1:0]        reg_addr;
  logic [DATA_W-1:0] pop_data, reg_rdata;
  logic              full, empty, alarm;

  int errors = 0;
  int checks = 0;
  bit done   = 0;
  string cur_req = "R1";

  // behavioural model state
  logic [DATA_W-1:0] q[$];
  bit m_ovf, m_unf, m_hi, m_lo, m_wfr, m_loen, m_hien;
  int m_gran, m_low;

  always #5 clk = ~clk;

  wm_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .push(push), .push_data(push_data), .pop(pop),
    .pop_data(pop_data), .full(full), .empty(empty), .alarm(alarm),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] model_reg(input logic [1:0] a);
    logic [DATA_W-1:0] v = '0;
    int lvl = q.size();
    case (a)
      2'd0: begin v[0] = m_wfr; v[1] = m_loen; v[2] = m_hien; v[6:4] = 3'(m_gran); end
      2'd1: v[LVL_W-1:0] = LVL_W'(m_low);
      2'd2: begin
        v[0] = (lvl == 0); v[1] = m_lo; v[2] = m_hi; v[3] = (lvl == DEPTH);
        v[4] = m_ovf; v[5] = m_unf; v[8 +: LVL_W] = LVL_W'(lvl);
      end
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic step(input bit ps, input logic [DATA_W-1:0] pd, input bit pp,
                      input bit wr, input bit rd, input logic [1:0] a,
                      input logic [DATA_W-1:0] wd);
    int lvl = q.size();
    bit mf = (lvl == DEPTH);
    bit me = (lvl == 0);
    bit sr = wr && (a == 2'd0) && wd[8];
    bit nhi, nlo;
    logic [DATA_W-1:0] er = '0;
    logic [DATA_W-1:0] ep = '0;
    push = ps; push_data = pd; pop = pp;
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
    if (rd) er = model_reg(a);
    nhi = ((DEPTH - lvl) <= m_gran);
    nlo = nhi ? 1'b0 : ((lvl <= m_low) ? 1'b1 : m_lo);
    if (pp && !me) ep = q.pop_front();
    if (ps && !mf && !sr) q.push_back(pd);
    if (sr) begin
      m_ovf = 0; m_unf = 0;
    end else begin
      if (ps && mf) m_ovf = 1;
      else if (wr && a == 2'd2 && wd[4]) m_ovf = 0;
      if (pp && me) m_unf = 1;
      else if (wr && a == 2'd2 && wd[5]) m_unf = 0;
    end
    if (sr) q.delete();
    if (wr && a == 2'd0) begin
      m_wfr = wd[0]; m_loen = wd[1]; m_hien = wd[2]; m_gran = int'(wd[6:4]);
    end
    if (wr && a == 2'd1) m_low = int'(wd[LVL_W-1:0]);
    m_hi = nhi; m_lo = nlo;
    @(posedge clk);
    @(negedge clk);
    check(full == (q.size() == DEPTH), cur_req, "full", DATA_W'(full), DATA_W'(q.size() == DEPTH));
    check(empty == (q.size() == 0), cur_req, "empty", DATA_W'(empty), DATA_W'(q.size() == 0));
    check(alarm == ((m_hi & m_hien) | (m_lo & m_loen)), cur_req, "alarm",
          DATA_W'(alarm), DATA_W'((m_hi & m_hien) | (m_lo & m_loen)));
    if (pp) check(pop_data == ep, cur_req, "pop_data", pop_data, ep);
    if (rd) check(reg_rdata == er, cur_req, "reg_rdata", reg_rdata, er);
  endtask

  task automatic idle();               step(0, '0, 0, 0, 0, 2'd0, '0); endtask
  task automatic push1(input logic [DATA_W-1:0] d); step(1, d, 0, 0, 0, 2'd0, '0); endtask
  task automatic pop1();               step(0, '0, 1, 0, 0, 2'd0, '0); endtask
  task automatic wreg(input logic [1:0] a, input logic [DATA_W-1:0] d); step(0, '0, 0, 1, 0, a, d); endtask
  task automatic rreg(input logic [1:0] a); step(0, '0, 0, 0, 1, a, '0); endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1; push = 0; pop = 0; reg_wr = 0; reg_rd = 0; reg_addr = '0;
    push_data = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(empty == 1'b1, "R1", "empty", DATA_W'(empty), 1);
    check(full == 1'b0, "R1", "full", DATA_W'(full), 0);
    check(alarm == 1'b0, "R1", "alarm", DATA_W'(alarm), 0);
    check(pop_data == '0, "R1", "pop_data", pop_data, 0);
    rst = 0;
    cur_req = "R1"; rreg(2'd0); rreg(2'd1); rreg(2'd2);
    // R2: ordering
    cur_req = "R2";
    for (int i = 0; i < 5; i++) push1(32'hA000_0000 + i);
    for (int i = 0; i < 5; i++) pop1();
    // R3: overflow, sticky, W1C, set beats clear
    cur_req = "R3";
    for (int i = 0; i < DEPTH; i++) push1(32'hB100_0000 + i);
    push1(32'hDEAD_BEEF);
    rreg(2'd2); idle(); rreg(2'd2);
    wreg(2'd2, 32'h10); rreg(2'd2);
    step(1, 32'h1234_5678, 0, 1, 0, 2'd2, 32'h10); rreg(2'd2);
    wreg(2'd2, 32'h10); rreg(2'd2);
    // R5: live full/empty and level field
    cur_req = "R5";
    for (int i = 0; i < DEPTH; i++) begin pop1(); rreg(2'd2); end
    // R4: underflow
    cur_req = "R4";
    pop1(); pop1(); rreg(2'd2); idle(); rreg(2'd2);
    wreg(2'd2, 32'h20); rreg(2'd2);
    // R13: simultaneous push and pop
    cur_req = "R13";
    step(1, 32'hC000_0001, 1, 0, 0, 2'd0, '0); rreg(2'd2);
    wreg(2'd2, 32'h20);
    push1(32'hC000_0002); push1(32'hC000_0003);
    step(1, 32'hC000_0004, 1, 0, 0, 2'd0, '0); rreg(2'd2);
    for (int i = 0; i < 3; i++) pop1();
    // R7 / R8: low alarm hysteresis, granularity 0
    cur_req = "R8";
    wreg(2'd1, 32'd2); wreg(2'd0, 32'h2);
    for (int i = 0; i < DEPTH; i++) begin push1(32'hD000_0000 + i); rreg(2'd2); end
    cur_req = "R7";
    for (int i = 0; i < DEPTH; i++) begin pop1(); rreg(2'd2); end
    cur_req = "R8";
    wreg(2'd0, 32'h12);
    for (int i = 0; i < DEPTH; i++) begin push1(32'hD100_0000 + i); rreg(2'd2); end
    for (int i = 0; i < DEPTH; i++) pop1();
    // R6 / R9: high flag, enables, largest granularity
    cur_req = "R6";
    wreg(2'd0, 32'h74);
    for (int i = 0; i < 4; i++) begin push1(32'hE000_0000 + i); rreg(2'd2); end
    cur_req = "R9";
    wreg(2'd0, 32'h76); idle(); wreg(2'd0, 32'h00); idle();
    wreg(2'd0, 32'h26); idle();
    for (int i = 0; i < 4; i++) pop1();
    idle(); idle();
    // R10: software reset with concurrent push
    cur_req = "R10";
    for (int i = 0; i < 5; i++) push1(32'hF000_0000 + i);
    push1(32'h1); pop1(); pop1(); pop1(); pop1(); pop1(); pop1();
    wreg(2'd2, 32'h30);
    push1(32'h2); push1(32'h3); push1(32'h4);
    step(1, 32'h5555_5555, 0, 1, 0, 2'd0, 32'h100); rreg(2'd2); rreg(2'd0);
    push1(32'h6666_0001); pop1();
    // R11: frame-end bit
    cur_req = "R11";
    wreg(2'd0, 32'h1); rreg(2'd0);
    push1(32'h7777_0001); push1(32'h7777_0002); pop1(); pop1();
    // R12: register port map
    cur_req = "R12";
    wreg(2'd1, 32'h5); rreg(2'd1); rreg(2'd3); rreg(2'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule